// File: doc/BRIEF.md
# Multiplexed-Bus Register Target

This block is the device side of a narrow host-controlled bus. The bus carries five shared data lines plus three control lines: an active-low chip select, a read/write select and an address/data phase select. The host runs every transaction by toggling these pins. The target first records a 5-bit register address. It then either takes a write value from the shared lines or returns the addressed register's contents on its own output lines, with an output enable that tells the pad logic when to drive.

All eight pins are sampled by a local clock through two-flop synchronisers. Every decision is made on the synchronised copies. A write is held until chip select goes high again, and only then is it committed.

The block has eight 5-bit state registers. They are written through a "set" window of addresses and read back through a separate "get" window. This lets the host check each write with a following read.

Top module: `pinbus_target`

## Requirements
- R1: After reset, `busOe` is 0, `busOut` is 0, and every register reads as zero.
- R2: While `csN` is high, bus activity writes nothing, latches no address and never asserts `busOe`. An address latched in an earlier transaction is kept across the idle interval.
- R3: While `csN` is low and `adSel` is 0, the target takes the `busIn` value as the register address. The last value seen before the phase ends is the one kept.
- R4: While `csN` is low with `adSel` = 1 and `rdWr` = 0, `busIn` is captured as write data. The write takes effect only when `csN` rises. A write to address 0x18+n (n = 0..7) sets register n.
- R5: While `csN` is low with `adSel` = 1 and `rdWr` = 1, `busOe` is 1. `busOut` then carries register n when the latched address is 0x10+n (n = 0..7).
- R6: A read of any address outside 0x10..0x17 returns zero. This includes the set window 0x18..0x1F.
- R7: A write to any address outside 0x18..0x1F changes no register.
- R8: `busOe` drops by the third clock edge after `csN` goes high, `rdWr` goes low or `adSel` goes low. `busOut` is zero whenever `busOe` is 0.
- R9: Pins pass through two synchroniser stages plus one output register. `busOe` rises at the third clock edge after the read-phase pins are applied, and not before.
- R10: If the write data on `busIn` changes during one data phase, the value present last before `csN` rises is the value stored.
- R11: A read transaction followed by a `csN` rise commits nothing, whatever `busIn` carries during its data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select from the host, active low |
| rdWr | input | 1 | 1 = host reads, 0 = host writes |
| adSel | input | 1 | 0 = address phase, 1 = data phase |
| busIn | input | 5 | Value the host places on the shared lines |
| busOut | output | 5 | Read data for the shared lines, zero when not driving |
| busOe | output | 1 | High while the target drives the shared lines |

## Verification
A wrong latched address shows up on the very next read-back: the get-window read returns the contents of a different register, or zero, about three cycles into the read data phase. A write-pending flag that is stuck or lost, or a commit decoded at the wrong time, leaves a register with the wrong value. That shows on the next get-window read, within one transaction of the faulty write. An error in the synchroniser depth or in the enable logic shows at once as `busOe` rising or falling one edge early or late.

// File: rtl/pinbus_pkg.sv
package pinbus_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic latchAddr;
    logic captureData;
    logic commitWrite;
    logic driveRead;
  } pinStrobes_t;

endpackage

// File: rtl/pinbus_sync.sv
// Multi-bit flop chain that brings asynchronous pins into the local clock domain.
module pinbus_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain[s] <= RESET_VAL;
      end else begin
        if (s == 0) chain[s] <= din;
        else        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pinbus_ctrl.sv
// Phase decode and commit timing, working on the synchronised pins.
module pinbus_ctrl
  import pinbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csSync,
  input  logic        rwSync,
  input  logic        adSync,
  output pinStrobes_t strobes
);

  logic csPrev;
  logic pendingWr;
  logic selected;
  logic csRise;

  assign selected = !csSync;
  assign csRise   = csSync && !csPrev;

  always_comb begin
    strobes.latchAddr   = selected && !adSync;
    strobes.captureData = selected &&  adSync && !rwSync;
    strobes.driveRead   = selected &&  adSync &&  rwSync;
    strobes.commitWrite = csRise && pendingWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev    <= 1'b1;
      pendingWr <= 1'b0;
    end else begin
      csPrev <= csSync;
      if (strobes.captureData)      pendingWr <= 1'b1;
      else if (strobes.commitWrite) pendingWr <= 1'b0;
    end
  end

endmodule

// File: rtl/pinbus_regs.sv
// Address/data holding registers, state register file and read path.
module pinbus_regs
  import pinbus_pkg::*;
#(
  parameter int BUS_W    = 5,
  parameter int NUM_REGS = 8,
  parameter int SET_BASE = 'h18,
  parameter int GET_BASE = 'h10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pinStrobes_t               strobes,
  input  logic [BUS_W-1:0]          busSync,
  output logic [BUS_W-1:0]          busOut,
  output logic                      busOe,
  output logic [NUM_REGS*BUS_W-1:0] regFlat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [BUS_W-1:0] SET_V = BUS_W'(SET_BASE);
  localparam logic [BUS_W-1:0] GET_V = BUS_W'(GET_BASE);
  localparam logic [BUS_W-1:0] CNT_V = BUS_W'(NUM_REGS);

  logic [BUS_W-1:0] addrReg;
  logic [BUS_W-1:0] dataReg;
  logic [BUS_W-1:0] regFile [NUM_REGS];
  logic [BUS_W-1:0] setOff, getOff;
  logic             setHit, getHit;
  logic [IDX_W-1:0] setIdx, getIdx;
  logic [BUS_W-1:0] readVal;

  // Window decode on the latched address.
  always_comb begin
    setOff  = addrReg - SET_V;
    getOff  = addrReg - GET_V;
    setHit  = (addrReg >= SET_V) && (setOff < CNT_V);
    getHit  = (addrReg >= GET_V) && (getOff < CNT_V);
    setIdx  = setOff[IDX_W-1:0];
    getIdx  = getOff[IDX_W-1:0];
    readVal = getHit ? regFile[getIdx] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobes.latchAddr)   addrReg <= busSync;
      if (strobes.captureData) dataReg <= busSync;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFile[i] <= '0;
      end else if (strobes.commitWrite && setHit && (setIdx == IDX_W'(i))) begin
        regFile[i] <= dataReg;
      end
    end
    assign regFlat[i*BUS_W +: BUS_W] = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busOe  <= 1'b0;
      busOut <= '0;
    end else begin
      busOe  <= strobes.driveRead;
      busOut <= strobes.driveRead ? readVal : '0;
    end
  end

endmodule

// File: rtl/pinbus_target.sv
// Thin top: pin synchronisers, control unit and datapath.
module pinbus_target
  import pinbus_pkg::*;
#(
  parameter int BUS_W       = 5,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdWr,
  input  logic             adSel,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe
);

  localparam int PIN_W = BUS_W + 3;

  logic [PIN_W-1:0]          pinsRaw, pinsSync;
  logic                      csSync, rwSync, adSync;
  logic [BUS_W-1:0]          busSync;
  pinStrobes_t               strobes;
  logic [NUM_REGS*BUS_W-1:0] regFlat;

  assign pinsRaw = {csN, rdWr, adSel, busIn};

  pinbus_sync #(
    .WIDTH(PIN_W), .STAGES(SYNC_STAGES),
    .RESET_VAL({3'b111, {BUS_W{1'b0}}})
  ) uSync (
    .clk(clk), .rstN(rstN), .din(pinsRaw), .dout(pinsSync)
  );

  assign {csSync, rwSync, adSync, busSync} = pinsSync;

  pinbus_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csSync(csSync), .rwSync(rwSync),
    .adSync(adSync), .strobes(strobes)
  );

  pinbus_regs #(
    .BUS_W(BUS_W), .NUM_REGS(NUM_REGS), .SET_BASE('h18), .GET_BASE('h10)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busSync(busSync),
    .busOut(busOut), .busOe(busOe), .regFlat(regFlat)
  );

endmodule

// File: rtl/pinbus_checker.sv
module pinbus_checker
  import pinbus_pkg::*;
#(
  parameter int BUS_W    = 5,
  parameter int NUM_REGS = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      csN,
  input logic                      rdWr,
  input logic                      adSel,
  input logic                      busOe,
  input logic [BUS_W-1:0]          busOut,
  input pinStrobes_t               strobes,
  input logic [NUM_REGS*BUS_W-1:0] regFlat
);

  // R8/R9: driving needs a read data phase with chip select low, three edges back
  assert_oe_needs_read_phase_R8: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (!$past(csN, 3) && $past(rdWr, 3) && $past(adSel, 3)));

  // R8: output lines stay quiet while not driving
  assert_idle_bus_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busOut == '0));

  // R9: phase strobes never overlap
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R4: register contents move only after a chip-select rise
  assert_regs_change_on_cs_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> ($past(csN, 3) && !$past(csN, 4)));

endmodule

bind pinbus_target pinbus_checker #(.BUS_W(BUS_W), .NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .adSel(adSel),
  .busOe(busOe), .busOut(busOut), .strobes(strobes), .regFlat(regFlat)
);

// File: tb/tb_pinbus_target.sv
`timescale 1ns/1ps
module tb_pinbus_target;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       rdWr = 1'b1;
  logic       adSel = 1'b1;
  logic [4:0] busIn = '0;
  logic [4:0] busOut;
  logic       busOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [4:0] model [8];

  always #4 clk = ~clk;

  pinbus_target dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdWr(rdWr), .adSel(adSel),
    .busIn(busIn), .busOut(busOut), .busOe(busOe)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [4:0] expRead(input logic [4:0] a);
    if (a >= 5'h10 && a <= 5'h17) return model[a - 5'h10];
    return 5'h00;
  endfunction

  // Full write transaction; data changes to d2 mid-phase when twoData is set.
  task automatic doWrite(input logic [4:0] a, input logic [4:0] d,
                         input bit twoData = 1'b0, input logic [4:0] d2 = '0);
    rdWr = 1'b0; adSel = 1'b0; busIn = a;
    stepN(5);
    csN = 1'b0;
    stepN(5);
    adSel = 1'b1; busIn = d;
    stepN(5);
    if (twoData) begin
      busIn = d2;
      stepN(5);
    end
    csN = 1'b1;
    stepN(5);
    rdWr = 1'b1;
    if (a >= 5'h18) model[a - 5'h18] = twoData ? d2 : d;
  endtask

  task automatic doRead(input logic [4:0] a, input string req);
    rdWr = 1'b1; adSel = 1'b0; busIn = a;
    stepN(5);
    csN = 1'b0;
    stepN(5);
    adSel = 1'b1; busIn = 5'h15;   // junk on input lines must not matter
    stepN(2);
    check("R9", "oe before third edge", busOe, 0);
    stepN(1);
    check("R9", "oe at third edge", busOe, 1);
    stepN(2);
    check(req, $sformatf("read addr %0h", a), busOut, expRead(a));
    csN = 1'b1;
    stepN(3);
    check("R8", "oe after cs high", busOe, 0);
    check("R8", "out after cs high", busOut, 0);
    stepN(2);
  endtask

  task automatic readAll(input string req);
    for (int a = 0; a < 32; a++) doRead(5'(a), req);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = '0;
    stepN(5);
    rstN = 1'b1;
    stepN(3);
    check("R1", "oe after reset", busOe, 0);
    check("R1", "out after reset", busOut, 0);
    readAll("R1");

    // R4/R5: every set-window register with every 5-bit value
    for (int n = 0; n < 8; n++) begin
      for (int v = 0; v < 32; v++) begin
        doWrite(5'(8'h18 + n), 5'(v));
        doRead(5'(8'h10 + n), "R4");
      end
    end

    // R5/R6: distinct contents, then read every address
    for (int n = 0; n < 8; n++) doWrite(5'(8'h18 + n), 5'((n * 3 + 7) & 31));
    readAll("R6");

    // R7: writes outside the set window change nothing
    for (int n = 0; n < 8; n++) doWrite(5'(8'h10 + n), 5'h00);
    doWrite(5'h00, 5'h1F);
    doWrite(5'h05, 5'h1F);
    doWrite(5'h0F, 5'h1F);
    readAll("R7");

    // R10: last data value before cs rise wins
    doWrite(5'h1A, 5'h05, 1'b1, 5'h1B);
    doRead(5'h12, "R10");

    // R3: address value changes within one address phase
    rdWr = 1'b0; adSel = 1'b0; busIn = 5'h1C;
    stepN(5);
    csN = 1'b0;
    stepN(5);
    busIn = 5'h1D;
    stepN(5);
    adSel = 1'b1; busIn = 5'h0E;
    stepN(5);
    csN = 1'b1;
    stepN(5);
    model[5] = 5'h0E;
    doRead(5'h15, "R3");
    doRead(5'h14, "R3");

    // R2: address latched, then idle activity with cs high
    rdWr = 1'b0; adSel = 1'b0; busIn = 5'h19;
    stepN(5);
    csN = 1'b0;
    stepN(5);
    csN = 1'b1;
    stepN(5);
    busIn = 5'h18;
    stepN(5);
    rdWr = 1'b1; adSel = 1'b1;
    stepN(5);
    check("R2", "oe with cs high", busOe, 0);
    rdWr = 1'b0; busIn = 5'h0A;
    stepN(5);
    csN = 1'b0;
    stepN(5);
    csN = 1'b1;
    stepN(5);
    model[1] = 5'h0A;
    doRead(5'h11, "R2");
    doRead(5'h10, "R2");

    // R11: read transaction commits nothing at cs rise
    doRead(5'h1B, "R11");
    for (int n = 0; n < 8; n++) doRead(5'(8'h10 + n), "R11");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule